// File: doc/BRIEF.md
# Four-Phase Event Handshake Across Clock Domains

This block carries single control events from a sending process to a receiving process when the two processes run on clocks with no fixed relationship. On the sending side, a one-cycle `start_i` pulse opens an exchange. The sender raises a request level, and that level crosses into the receiving clock domain through a multi-flop synchronizer. The receiver answers with an acknowledge level, which crosses back the same way. The exchange returns to zero in four phases.

While an exchange is open, the sender shows `busy_o` and drops any new start. When the acknowledge has returned low, the sender gives one `done_o` pulse. The receiver turns each rising request into a single `strobe_o` pulse of one receive-clock cycle. No data moves with the event.

Each domain has its own active-low reset. The reset takes effect at once and is released in step with that domain's clock.

Top module: `evt_handshake_sync`

## Requirements
- R1: While either reset is low, and after both resets are released with no start, `busy_o`, `done_o` and `strobe_o` stay 0. Releasing reset produces no strobe.
- R2: A start pulse taken while `busy_o` is 0 makes `busy_o` read 1 in the next sender cycle.
- R3: A start pulse that arrives while `busy_o` is 1 has no effect. It adds no strobe, and the exchange ends with a single `done_o`.
- R4: Each accepted start produces exactly one `strobe_o` pulse, and that pulse is one receive-clock cycle wide. With no start, no strobe occurs.
- R5: `done_o` is high for exactly one sender cycle per accepted start. In that cycle `busy_o` is already 0.
- R6: The handshake keeps its four-phase order. The request stays high until the acknowledge is seen high. The acknowledge rises only after a request has been seen high. The request falls only after the acknowledge has been seen high. The strobe for an event comes before that event's `done_o`.
- R7: A start given in the cycle where `done_o` is high is accepted, because `busy_o` is 0 there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_snd | input | 1 | Sender clock |
| rst_snd_n | input | 1 | Sender reset, active low |
| clk_rcv | input | 1 | Receiver clock, unrelated to the sender clock |
| rst_rcv_n | input | 1 | Receiver reset, active low |
| start_i | input | 1 | One-cycle event request, sender domain |
| busy_o | output | 1 | An exchange is open |
| done_o | output | 1 | One-cycle pulse when the exchange has closed |
| strobe_o | output | 1 | One-cycle pulse per event, receiver domain |

## Verification
The assertions assume that `start_i` changes only in step with the sender clock. They also assume that both resets are released before any start is given, and that neither side is reset during an open exchange, since a one-sided reset would break the request/acknowledge pairing. The stimulus drives `start_i` on falling sender edges only. It resets both domains together and only while the block is idle. The two clocks run at periods of 10 and 14 time units, so their edge phases slide against each other from one event to the next.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int MIN_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    SND_IDLE      = 2'd0,
    SND_WAIT_ACK  = 2'd1,
    SND_WAIT_DROP = 2'd2
  } snd_state_e;
endpackage

// File: rtl/hs_rst_sync.sv
module hs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic lvl_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      dly_q   <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_async};
      dly_q   <= chain_q[STAGES-1];
    end
  end

  assign lvl_o = chain_q[STAGES-1];

  generate
    if (FALLING) begin : g_fall
      assign edge_o = dly_q & ~lvl_o;
    end else begin : g_rise
      assign edge_o = lvl_o & ~dly_q;
    end
  endgenerate

  // R4/R5: an edge pulse never lasts two cycles
  a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/hs_sender.sv
module hs_sender
  import hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ack_async_i,
  output logic req_o,
  output logic busy_o,
  output logic done_o
);
  snd_state_e state_q, state_d;
  logic       req_q, req_d;
  logic       done_q, done_d;
  logic       ack_lvl, ack_fall;

  hs_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_ack_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ack_async_i),
    .lvl_o   (ack_lvl),
    .edge_o  (ack_fall)
  );

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    done_d  = 1'b0;
    case (state_q)
      SND_IDLE: begin
        if (start_i) begin
          state_d = SND_WAIT_ACK;
          req_d   = 1'b1;
        end
      end
      SND_WAIT_ACK: begin
        if (ack_lvl) begin
          state_d = SND_WAIT_DROP;
          req_d   = 1'b0;
        end
      end
      SND_WAIT_DROP: begin
        if (ack_fall) begin
          state_d = SND_IDLE;
          done_d  = 1'b1;
        end
      end
      default: begin
        state_d = SND_IDLE;
        req_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SND_IDLE;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      done_q  <= done_d;
    end
  end

  assign req_o  = req_q;
  assign busy_o = (state_q != SND_IDLE);
  assign done_o = done_q;

  // R6: request held until acknowledge observed
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_lvl) |=> req_q);
  // R6: request only falls after acknowledge seen high
  a_r6_req_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(ack_lvl));
  // R3: a new request only opens from the idle state
  a_r3_accept_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(!busy_o));
  // R5: done is a single cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5: done only once the loop is fully back to zero
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !req_q && !ack_lvl));
endmodule

// File: rtl/hs_receiver.sv
module hs_receiver #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async_i,
  output logic ack_o,
  output logic strobe_o
);
  logic req_lvl;
  logic req_rise;
  logic ack_q;

  hs_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_req_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (req_async_i),
    .lvl_o   (req_lvl),
    .edge_o  (req_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= req_lvl;
  end

  assign ack_o    = ack_q;
  assign strobe_o = req_rise;

  // R6: acknowledge rises only after the strobe for a seen request
  a_r6_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(strobe_o));
  // R4: strobe is one receive cycle wide
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/evt_handshake_sync.sv
module evt_handshake_sync
  import hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_snd,
  input  logic rst_snd_n,
  input  logic clk_rcv,
  input  logic rst_rcv_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic strobe_o
);
  localparam int STAGES_USED = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic snd_rst_n, rcv_rst_n;
  logic req, ack;

  hs_rst_sync #(.STAGES(STAGES_USED)) u_rst_snd (
    .clk (clk_snd), .arst_n (rst_snd_n), .rst_n_o (snd_rst_n));

  hs_rst_sync #(.STAGES(STAGES_USED)) u_rst_rcv (
    .clk (clk_rcv), .arst_n (rst_rcv_n), .rst_n_o (rcv_rst_n));

  hs_sender #(.SYNC_STAGES(STAGES_USED)) u_snd (
    .clk         (clk_snd),
    .rst_n       (snd_rst_n),
    .start_i     (start_i),
    .ack_async_i (ack),
    .req_o       (req),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  hs_receiver #(.SYNC_STAGES(STAGES_USED)) u_rcv (
    .clk         (clk_rcv),
    .rst_n       (rcv_rst_n),
    .req_async_i (req),
    .ack_o       (ack),
    .strobe_o    (strobe_o)
  );
endmodule

// File: tb/evt_handshake_sync_tb_top.sv
module evt_handshake_sync_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RCV_HALF   = 7;
  localparam int WAIT_LIMIT = 400;
  localparam int N_VEC      = 8;
  // vector: [15:12] start cycles held, [11:8] late start flag, [7:0] idle gap
  localparam logic [15:0] VEC [N_VEC] = '{
    16'h1003, 16'h1000, 16'h3007, 16'h0014,
    16'h1105, 16'h4101, 16'h100B, 16'h2102
  };

  logic clk_snd = 1'b0, clk_rcv = 1'b0;
  logic rst_snd_n = 1'b0, rst_rcv_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o, strobe_o;

  int n_checks = 0, n_fail = 0;
  int strobe_cnt = 0;
  bit strobe_prev = 1'b0, strobe_wide = 1'b0;
  bit done_prev = 1'b0, done_wide = 1'b0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk_snd = ~clk_snd;
  always #(RCV_HALF) clk_rcv = ~clk_rcv;

  evt_handshake_sync dut_i (
    .clk_snd (clk_snd), .rst_snd_n (rst_snd_n),
    .clk_rcv (clk_rcv), .rst_rcv_n (rst_rcv_n),
    .start_i (start_i), .busy_o (busy_o),
    .done_o  (done_o),  .strobe_o (strobe_o)
  );

  always @(negedge clk_rcv) begin
    if (strobe_o) strobe_cnt++;
    if (strobe_o && strobe_prev) strobe_wide = 1'b1;
    strobe_prev = strobe_o;
  end

  always @(negedge clk_snd) begin
    if (done_o && done_prev) done_wide = 1'b1;
    done_prev = done_o;
    cycles++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_snd);
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < WAIT_LIMIT; i++) begin
      @(negedge clk_snd);
      if (done_o) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    bit seen;
    int s0;
    idle(3);
    check(!busy_o && !done_o && !strobe_o, "R1 in reset", {busy_o, done_o, strobe_o}, 0);
    rst_snd_n = 1'b1;
    rst_rcv_n = 1'b1;
    idle(20);
    check(strobe_cnt == 0 && !busy_o, "R1 after release", strobe_cnt, 0);

    for (int v = 0; v < N_VEC; v++) begin
      idle(int'(VEC[v][7:0]));
      s0 = strobe_cnt;
      if (VEC[v][15:12] == 0) begin
        idle(30);
        check(strobe_cnt == s0 && !busy_o, "R4 no start no strobe", strobe_cnt - s0, 0);
        continue;
      end
      start_i = 1'b1;
      @(negedge clk_snd);
      check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
      for (int k = 1; k < int'(VEC[v][15:12]); k++) @(negedge clk_snd);
      start_i = 1'b0;
      if (VEC[v][8]) begin
        idle(5);
        if (busy_o) begin
          start_i = 1'b1;
          @(negedge clk_snd);
          start_i = 1'b0;
        end
      end
      wait_done(seen);
      check(seen, "R5 done arrives", seen, 1);
      check(!busy_o, "R5 busy low with done", busy_o, 0);
      check(strobe_cnt - s0 == 1, "R6 strobe before done", strobe_cnt - s0, 1);
      idle(30);
      check(strobe_cnt - s0 == 1, "R3 one strobe per accepted start", strobe_cnt - s0, 1);
      check(!busy_o && !done_o, "R5 single done then idle", {busy_o, done_o}, 0);
    end

    // R7: start in the done cycle is accepted
    s0 = strobe_cnt;
    start_i = 1'b1;
    @(negedge clk_snd);
    start_i = 1'b0;
    wait_done(seen);
    start_i = 1'b1;
    @(negedge clk_snd);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R7 start on done accepted", busy_o, 1);
    wait_done(seen);
    check(seen && strobe_cnt - s0 == 2, "R7 two events", strobe_cnt - s0, 2);

    // R1: reset while idle, no spurious strobe on release
    idle(10);
    rst_snd_n = 1'b0;
    rst_rcv_n = 1'b0;
    s0 = strobe_cnt;
    idle(4);
    check(!busy_o && !done_o && !strobe_o, "R1 reset again", {busy_o, done_o, strobe_o}, 0);
    rst_snd_n = 1'b1;
    rst_rcv_n = 1'b1;
    idle(25);
    check(strobe_cnt == s0 && !busy_o, "R1 no strobe at release", strobe_cnt - s0, 0);

    check(!strobe_wide, "R4 strobe width", strobe_wide, 0);
    check(!done_wide, "R5 done width", done_wide, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule